// File: doc/BRIEF.md
# DRAM Read Burst Scheduler

This block models the device side of a synchronous DRAM read path whose command bus runs a fixed number of clocks behind chip select. It watches an active-low chip select and, when a select is accepted, samples the command code, bank group and column exactly `TCAL` clocks later. The clocks in between count as deselect. A READ captured this way is queued with a start time `RL` clocks ahead. When that time arrives, the block drives a burst of column-derived data beats, two per clock, framed by a one-clock strobe preamble and a one-clock postamble.

The burst length is chosen per READ from a two-bit mode field and the A12 bit. Reads to different bank groups may follow each other every four clocks and then stream without a gap. A read that comes too soon after the previous one to the same bank group, or too soon after any read, sets a sticky violation flag. So does a read that arrives while the pending queue is full. Tri-state is represented by output-enable signals.

Top module: `dram_rd_burst_sched`

## Requirements
- R1: A low `cs_n` is accepted at a rising edge only when no capture is pending or when the pending capture falls on that same edge. The command is sampled `TCAL`=4 edges after the accepting edge. `cs_n` lows and command codes at all other edges are ignored.
- R2: Only command code 3'b101 (READ) at a capture edge schedules a burst. Any other code there produces no strobe or data activity.
- R3: For a READ captured at edge C, `dq_valid` is first high in the cycle after edge C+RL (RL=11) and never earlier.
- R4: In the cycle before a burst window, `dqs_oe`=1 and `dqs_toggle`=0 (preamble), unless the previous burst's window occupies that cycle.
- R5: In the cycle after a window that is not directly followed by another window, `dqs_oe`=1 with `dqs_toggle`=0 (postamble). Outside windows, preambles and postambles, `dqs_oe`, `dq_oe` and `dqs_toggle` are 0.
- R6: In window cycle b (0..3), `dq_rise` carries the column {col[9:3], col[2:0]+2b} and `dq_fall` carries {col[9:3], col[2:0]+2b+1}, with the low three bits wrapping modulo 8. In cycles without valid data both are 0.
- R7: Mode 2'b00 and 2'b11 give 8 beats. Mode 2'b01 gives 8 beats with A12=1 and 4 beats with A12=0. Mode 2'b10 gives 4 beats. A 4-beat burst keeps `dqs_toggle` and `dq_oe` high for all 4 window cycles but has `dq_valid`=1 only in the first 2.
- R8: READs to different bank groups captured 4 clocks apart produce back-to-back windows with no idle or preamble cycle between them.
- R9: `timing_viol` rises after a READ captured fewer than `TCCD_L`=6 clocks after the previous READ to the same bank group, or fewer than `TCCD_S`=4 clocks after any READ, or while the queue is full. It then stays high until reset.
- R10: A synchronous active-high reset clears pending reads and the violation flag and drives all outputs to 0. A read captured before the reset produces no burst afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| cmd | input | 3 | Command code, READ = 3'b101 |
| bg | input | 2 | Bank group |
| col | input | 10 | Column address |
| a12 | input | 1 | On-the-fly burst selector, 1 = 8 beats |
| burst_mode | input | 2 | Burst length mode field |
| dq_rise | output | 10 | Data beat for the rising clock half |
| dq_fall | output | 10 | Data beat for the falling clock half |
| dq_oe | output | 1 | Data pins driven |
| dqs_oe | output | 1 | Strobe pins driven |
| dqs_toggle | output | 1 | Strobe toggling this cycle |
| dq_valid | output | 1 | Data beats in this cycle carry read data |
| timing_viol | output | 1 | Sticky command spacing violation |

## Verification
The hardest situation to reach from the ports is a chip select pulse that arrives while a capture is still pending, with a READ code on the bus at the edge where a wrongly accepted select would have been sampled. A directed case forces select pulses and READ codes into the deselect edges of a pending capture. The random phase scatters further select pulses there. Seamless streaming and the collision between one burst's postamble and the next burst's preamble are reached by placing reads exactly 4 and 5 clocks apart. A reset is dropped between a capture and its data window.

// File: rtl/rdsched_pkg.sv
package rdsched_pkg;
    localparam int COL_W = 10;
    localparam int BG_W  = 2;
    localparam int CMD_W = 3;
    localparam int TS_W  = 8;
    localparam logic [CMD_W-1:0] CMD_READ = 3'b101;

    typedef enum logic [1:0] {
        BM_FIXED8 = 2'b00,
        BM_OTF    = 2'b01,
        BM_FIXED4 = 2'b10,
        BM_ALT8   = 2'b11
    } bmode_e;

    typedef struct packed {
        logic [BG_W-1:0]  bg;
        logic [COL_W-1:0] col;
        logic             chop;
    } rd_req_t;

    typedef struct packed {
        logic [TS_W-1:0]  start;
        logic [COL_W-1:0] col;
        logic             chop;
    } rd_slot_t;

    function automatic logic chop_sel(bmode_e m, logic sel8);
        return (m == BM_FIXED4) || (m == BM_OTF && !sel8);
    endfunction

    function automatic logic [COL_W-1:0] beat_col(logic [COL_W-1:0] base, logic [2:0] idx);
        return {base[COL_W-1:3], base[2:0] + idx};
    endfunction
endpackage

// File: rtl/rdsched_cal_capture.sv
module rdsched_cal_capture
    import rdsched_pkg::*;
#(
    parameter int TCAL = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic [CMD_W-1:0] cmd,
    input  logic [BG_W-1:0]  bg,
    input  logic [COL_W-1:0] col,
    input  logic             a12,
    input  logic [1:0]       burst_mode,
    output logic             req_v,
    output rd_req_t          req
);
    localparam int CW = $clog2(TCAL + 1);

    logic [CW-1:0] wait_q;
    logic          due;
    logic          take;

    assign due   = (wait_q == CW'(1));
    assign take  = !cs_n && (wait_q == '0 || due);
    assign req_v = due && (cmd == CMD_READ);
    assign req   = '{bg: bg, col: col, chop: chop_sel(bmode_e'(burst_mode), a12)};

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q <= '0;
        end else if (take) begin
            wait_q <= CW'(TCAL);
        end else if (wait_q != '0) begin
            wait_q <= wait_q - CW'(1);
        end
    end

    // R1: a capture always traces back to a select sampled low TCAL edges earlier
    p_cal_gap_r1: assert property (@(posedge clk) disable iff (rst)
        req_v |-> !$past(cs_n, TCAL));
endmodule

// File: rtl/rdsched_queue.sv
module rdsched_queue
    import rdsched_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  rd_slot_t din,
    input  logic     pop,
    output logic     head_v,
    output rd_slot_t head,
    output logic     drop
);
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    rd_slot_t        mem [DEPTH];
    logic [PW-1:0]   wp, rp;
    logic [CNTW-1:0] cnt;
    logic            full, push_ok, pop_ok;

    assign full    = (cnt == CNTW'(DEPTH));
    assign head_v  = (cnt != '0);
    assign head    = mem[rp];
    assign push_ok = push && !full;
    assign pop_ok  = pop && head_v;
    assign drop    = push && full;

    function automatic logic [PW-1:0] wrap_inc(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push_ok) begin
                mem[wp] <= din;
                wp      <= wrap_inc(wp);
            end
            if (pop_ok) begin
                rp <= wrap_inc(rp);
            end
            cnt <= cnt + CNTW'(push_ok) - CNTW'(pop_ok);
        end
    end

    // R3: the burst engine only starts a burst that is actually pending
    p_pop_has_head_r3: assert property (@(posedge clk) disable iff (rst)
        pop |-> head_v);
endmodule

// File: rtl/rdsched_burst.sv
module rdsched_burst
    import rdsched_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             head_v,
    input  rd_slot_t         head,
    output logic             pop,
    output logic [TS_W-1:0]  now,
    output logic [COL_W-1:0] dq_rise,
    output logic [COL_W-1:0] dq_fall,
    output logic             dq_oe,
    output logic             dqs_oe,
    output logic             dqs_toggle,
    output logic             dq_valid
);
    logic [TS_W-1:0]  now_q, nxt;
    logic             act_q, act_n;
    logic [1:0]       beat_q, beat_n;
    logic [COL_W-1:0] col_q, col_n;
    logic             chop_q, chop_n;
    logic             start, pre, post, live;

    always_comb begin
        nxt    = now_q + TS_W'(1);
        start  = head_v && (head.start == nxt);
        act_n  = act_q;
        beat_n = beat_q;
        col_n  = col_q;
        chop_n = chop_q;
        if (start) begin
            act_n  = 1'b1;
            beat_n = 2'd0;
            col_n  = head.col;
            chop_n = head.chop;
        end else if (act_q && beat_q != 2'd3) begin
            beat_n = beat_q + 2'd1;
        end else begin
            act_n = 1'b0;
        end
        pre  = head_v && (head.start == nxt + TS_W'(1));
        post = act_q && (beat_q == 2'd3) && !act_n;
        live = act_n && !(chop_n && beat_n[1]);
    end

    assign pop = start;
    assign now = now_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            now_q      <= '0;
            act_q      <= 1'b0;
            beat_q     <= 2'd0;
            col_q      <= '0;
            chop_q     <= 1'b0;
            dq_rise    <= '0;
            dq_fall    <= '0;
            dq_oe      <= 1'b0;
            dqs_oe     <= 1'b0;
            dqs_toggle <= 1'b0;
            dq_valid   <= 1'b0;
        end else begin
            now_q      <= nxt;
            act_q      <= act_n;
            beat_q     <= beat_n;
            col_q      <= col_n;
            chop_q     <= chop_n;
            dqs_toggle <= act_n;
            dq_oe      <= act_n;
            dqs_oe     <= act_n || pre || post;
            dq_valid   <= live;
            dq_rise    <= live ? beat_col(col_n, {beat_n, 1'b0}) : '0;
            dq_fall    <= live ? beat_col(col_n, {beat_n, 1'b1}) : '0;
        end
    end

    // R4: a strobe that starts toggling was driven in the cycle before
    p_preamble_first_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(dqs_toggle) |-> $past(dqs_oe));

    // R5: the strobe stays driven for one cycle after toggling stops
    p_postamble_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(dqs_toggle) |-> dqs_oe);

    // R7: valid data only inside a driven, toggling window
    p_valid_in_window_r7: assert property (@(posedge clk) disable iff (rst)
        dq_valid |-> (dqs_toggle && dq_oe));
endmodule

// File: rtl/rdsched_spacing.sv
module rdsched_spacing
    import rdsched_pkg::*;
#(
    parameter int TCCD_S = 4,
    parameter int TCCD_L = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_v,
    input  logic [BG_W-1:0] req_bg,
    input  logic            drop,
    output logic            viol
);
    localparam int NBG  = 1 << BG_W;
    localparam int GMAX = (TCCD_L > TCCD_S) ? TCCD_L : TCCD_S;
    localparam int GW   = $clog2(GMAX + 1);

    logic [GW-1:0] gap_any;
    logic [GW-1:0] gap_bg [NBG];
    logic          hit;

    function automatic logic [GW-1:0] sat_inc(logic [GW-1:0] g);
        return (g < GW'(GMAX)) ? g + GW'(1) : g;
    endfunction

    assign hit = drop || (req_v && ((gap_any < GW'(TCCD_S)) ||
                                    (gap_bg[req_bg] < GW'(TCCD_L))));

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_any <= GW'(GMAX);
            viol    <= 1'b0;
        end else begin
            gap_any <= req_v ? GW'(1) : sat_inc(gap_any);
            viol    <= viol | hit;
        end
    end

    for (genvar g = 0; g < NBG; g++) begin : g_grp
        always_ff @(posedge clk) begin
            if (rst) begin
                gap_bg[g] <= GW'(GMAX);
            end else if (req_v && req_bg == BG_W'(g)) begin
                gap_bg[g] <= GW'(1);
            end else begin
                gap_bg[g] <= sat_inc(gap_bg[g]);
            end
        end
    end

    // R9: once raised, the violation flag holds until reset
    p_viol_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        $past(viol) |-> viol);
endmodule

// File: rtl/dram_rd_burst_sched.sv
module dram_rd_burst_sched
    import rdsched_pkg::*;
#(
    parameter int RL     = 11,
    parameter int TCAL   = 4,
    parameter int TCCD_S = 4,
    parameter int TCCD_L = 6,
    parameter int QDEPTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic [CMD_W-1:0] cmd,
    input  logic [BG_W-1:0]  bg,
    input  logic [COL_W-1:0] col,
    input  logic             a12,
    input  logic [1:0]       burst_mode,
    output logic [COL_W-1:0] dq_rise,
    output logic [COL_W-1:0] dq_fall,
    output logic             dq_oe,
    output logic             dqs_oe,
    output logic             dqs_toggle,
    output logic             dq_valid,
    output logic             timing_viol
);
    localparam logic [TS_W-1:0] LEAD = TS_W'(RL + 1);

    logic            req_v;
    rd_req_t         req;
    rd_slot_t        slot;
    logic            head_v, pop, drop;
    rd_slot_t        head;
    logic [TS_W-1:0] now;

    rdsched_cal_capture #(.TCAL(TCAL)) u_cap (
        .clk(clk), .rst(rst), .cs_n(cs_n), .cmd(cmd), .bg(bg), .col(col),
        .a12(a12), .burst_mode(burst_mode), .req_v(req_v), .req(req)
    );

    assign slot = '{start: now + LEAD, col: req.col, chop: req.chop};

    rdsched_queue #(.DEPTH(QDEPTH)) u_q (
        .clk(clk), .rst(rst), .push(req_v), .din(slot), .pop(pop),
        .head_v(head_v), .head(head), .drop(drop)
    );

    rdsched_burst u_eng (
        .clk(clk), .rst(rst), .head_v(head_v), .head(head), .pop(pop),
        .now(now), .dq_rise(dq_rise), .dq_fall(dq_fall), .dq_oe(dq_oe),
        .dqs_oe(dqs_oe), .dqs_toggle(dqs_toggle), .dq_valid(dq_valid)
    );

    rdsched_spacing #(.TCCD_S(TCCD_S), .TCCD_L(TCCD_L)) u_sp (
        .clk(clk), .rst(rst), .req_v(req_v), .req_bg(req.bg), .drop(drop),
        .viol(timing_viol)
    );
endmodule

// File: tb/tb_dram_rd_burst_sched.sv
module tb_dram_rd_burst_sched;
    localparam int N      = 3000;
    localparam int RL     = 11;
    localparam int TCAL   = 4;
    localparam int TCCD_S = 4;
    localparam int TCCD_L = 6;
    localparam logic [2:0] RD = 3'b101;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst, cs_n, a12;
    logic [2:0] cmd;
    logic [1:0] bg, burst_mode;
    logic [9:0] col, dq_rise, dq_fall;
    logic       dq_oe, dqs_oe, dqs_toggle, dq_valid, timing_viol;

    dram_rd_burst_sched dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .cmd(cmd), .bg(bg), .col(col),
        .a12(a12), .burst_mode(burst_mode), .dq_rise(dq_rise), .dq_fall(dq_fall),
        .dq_oe(dq_oe), .dqs_oe(dqs_oe), .dqs_toggle(dqs_toggle),
        .dq_valid(dq_valid), .timing_viol(timing_viol)
    );

    // stimulus plan
    logic       p_cs [N];
    logic       p_rst [N];
    logic [2:0] p_cmd [N];
    logic [1:0] p_bg [N];
    logic [9:0] p_col [N];
    logic       p_a12 [N];
    logic [1:0] p_mode [N];
    // expected outputs per cycle
    logic       e_tog [N];
    logic       e_dqsoe [N];
    logic       e_dqoe [N];
    logic       e_val [N];
    logic       e_viol [N];
    logic [9:0] e_r [N];
    logic [9:0] e_f [N];
    string      e_note [N];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    function automatic logic [9:0] bcol(logic [9:0] c, int idx);
        logic [2:0] lo;
        lo = c[2:0] + 3'(idx);
        return {c[9:3], lo};
    endfunction

    function automatic bit is_chop(logic [1:0] m, logic s);
        return (m == 2'b10) || (m == 2'b01 && !s);
    endfunction

    task automatic place(int e, logic [1:0] g, logic [9:0] c, logic [1:0] m, logic s,
                         logic [2:0] code);
        p_cs[e] = 1'b1;
        for (int k = 1; k < TCAL; k++) if ($urandom % 3 == 0) p_cs[e+k] = 1'b1;
        p_cmd[e+TCAL]  = code;
        p_bg[e+TCAL]   = g;
        p_col[e+TCAL]  = c;
        p_mode[e+TCAL] = m;
        p_a12[e+TCAL]  = s;
    endtask

    task automatic note(int a, int b, string t);
        for (int m = a; m <= b; m++) e_note[m] = t;
    endtask

    task automatic fill(int c, logic [9:0] cl, bit chop);
        int s;
        s = c + RL;
        for (int b = 0; b < 4; b++) begin
            bit lv;
            lv = !(chop && b >= 2);
            e_tog[s+b]   = 1'b1;
            e_dqoe[s+b]  = 1'b1;
            e_dqsoe[s+b] = 1'b1;
            e_val[s+b]   = lv;
            e_r[s+b]     = lv ? bcol(cl, 2*b) : 10'd0;
            e_f[s+b]     = lv ? bcol(cl, 2*b+1) : 10'd0;
        end
        if (!e_tog[s-1]) e_dqsoe[s-1] = 1'b1;
        if (!e_tog[s+4]) e_dqsoe[s+4] = 1'b1;
    endtask

    task automatic model();
        int due, last_any;
        int last_bg [4];
        bit viol;
        due = -1; last_any = -1000; viol = 1'b0;
        for (int g = 0; g < 4; g++) last_bg[g] = -1000;
        for (int n = 0; n < N; n++) begin
            if (p_rst[n]) begin
                due = -1; last_any = -1000; viol = 1'b0;
                for (int g = 0; g < 4; g++) last_bg[g] = -1000;
                for (int m = n; m < N; m++) begin
                    e_tog[m] = 0; e_dqsoe[m] = 0; e_dqoe[m] = 0; e_val[m] = 0;
                    e_r[m] = '0; e_f[m] = '0;
                end
                e_viol[n] = 1'b0;
                continue;
            end
            if (due == n) begin
                due = -1;
                if (p_cmd[n] == RD) begin
                    if (n - last_any < TCCD_S || n - last_bg[p_bg[n]] < TCCD_L) viol = 1'b1;
                    last_any = n;
                    last_bg[p_bg[n]] = n;
                    fill(n, p_col[n], is_chop(p_mode[n], p_a12[n]));
                end
            end
            if (p_cs[n] && due == -1) due = n + TCAL;
            e_viol[n] = viol;
        end
    endtask

    task automatic chk(int n, logic [9:0] act, logic [9:0] exp, string tag, string what);
        string t;
        t = (e_note[n] != "") ? e_note[n] : (p_rst[n] ? "R10" : tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s cycle %0d: actual=%0h expected=%0h", t, what, n, act, exp);
        end
    endtask

    initial begin
        int cur;
        void'($urandom(32'd4242));
        for (int n = 0; n < N; n++) begin
            p_cs[n] = 0; p_rst[n] = (n < 4); p_cmd[n] = 3'($urandom);
            p_bg[n] = 2'($urandom); p_col[n] = 10'($urandom); p_a12[n] = 1'($urandom);
            p_mode[n] = 2'($urandom);
            e_tog[n] = 0; e_dqsoe[n] = 0; e_dqoe[n] = 0; e_val[n] = 0; e_viol[n] = 0;
            e_r[n] = '0; e_f[n] = '0; e_note[n] = "";
        end
        cur = 8;
        // R3/R6: fixed 8-beat burst, low column bits wrap
        place(cur, 2'd0, 10'h0F5, 2'b00, 1'b0, RD); cur += 20;
        // R7: every burst mode
        place(cur, 2'd1, 10'h2A0, 2'b01, 1'b1, RD); cur += 20;
        place(cur, 2'd2, 10'h013, 2'b01, 1'b0, RD); cur += 20;
        place(cur, 2'd3, 10'h1FE, 2'b10, 1'b1, RD); cur += 20;
        place(cur, 2'd0, 10'h3C7, 2'b11, 1'b0, RD); cur += 20;
        // R1: select pulses and READ codes in the deselect edges are ignored
        place(cur, 2'd1, 10'h155, 2'b00, 1'b0, RD);
        for (int k = 1; k < TCAL; k++) begin p_cs[cur+k] = 1'b1; p_cmd[cur+k] = RD; end
        p_cmd[cur+TCAL+1] = RD; p_cmd[cur+TCAL+2] = RD;
        note(cur + TCAL + RL - 1, cur + TCAL + RL + 8, "R1"); cur += 26;
        // R2: non-READ code at the capture edge
        place(cur, 2'd2, 10'h0AA, 2'b00, 1'b0, 3'b001);
        note(cur + TCAL + RL - 1, cur + TCAL + RL + 5, "R2"); cur += 22;
        // R8: seamless reads to different bank groups
        place(cur, 2'd0, 10'h008, 2'b00, 1'b0, RD);
        place(cur + 4, 2'd1, 10'h10C, 2'b01, 1'b1, RD);
        place(cur + 8, 2'd2, 10'h207, 2'b00, 1'b0, RD);
        note(cur + TCAL + RL - 1, cur + 8 + TCAL + RL + 4, "R8"); cur += 32;
        // R4/R5: postamble meets preamble at a spacing of 5
        place(cur, 2'd3, 10'h061, 2'b00, 1'b0, RD);
        place(cur + 5, 2'd0, 10'h0F2, 2'b10, 1'b0, RD); cur += 26;
        // R9: same bank group 4 clocks apart
        place(cur, 2'd2, 10'h033, 2'b00, 1'b0, RD);
        place(cur + 4, 2'd2, 10'h044, 2'b00, 1'b0, RD); cur += 26;
        // R10: reset between capture and data window
        place(cur, 2'd1, 10'h3FF, 2'b00, 1'b0, RD);
        p_rst[cur+8] = 1'b1; p_rst[cur+9] = 1'b1;
        note(cur + 8, cur + TCAL + RL + 6, "R10"); cur += 30;
        // random phase
        while (cur < N - 40) begin
            place(cur, 2'($urandom), 10'($urandom), 2'($urandom), 1'($urandom),
                  ($urandom % 8 == 0) ? 3'b011 : RD);
            cur += $urandom_range(4, 12);
        end
        model();

        for (int n = 0; n < N; n++) begin
            rst = p_rst[n]; cs_n = !p_cs[n]; cmd = p_cmd[n]; bg = p_bg[n];
            col = p_col[n]; a12 = p_a12[n]; burst_mode = p_mode[n];
            @(posedge clk);
            @(negedge clk);
            chk(n, 10'(dq_valid), 10'(e_val[n]), "R3", "dq_valid");
            chk(n, 10'(dqs_toggle), 10'(e_tog[n]), "R7", "dqs_toggle");
            chk(n, 10'(dqs_oe), 10'(e_dqsoe[n]), "R4", "dqs_oe");
            chk(n, 10'(dq_oe), 10'(e_dqoe[n]), "R5", "dq_oe");
            chk(n, dq_rise, e_r[n], "R6", "dq_rise");
            chk(n, dq_fall, e_f[n], "R6", "dq_fall");
            chk(n, 10'(timing_viol), 10'(e_viol[n]), "R9", "timing_viol");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule